// File: doc/BRIEF.md
# Line-Splitting Copy Timing Engine

The block accepts a copy request for on-chip local memory and breaks it into line-sized bus transactions. A request gives a source byte address, the destination's offset within a line, and a byte count. The engine emits one transaction for every 128-byte source line that the range touches. Each transaction carries the line-aligned source address, a per-byte enable mask and a flag on the final one.

Timing follows a fixed cost model rather than size over bandwidth. A fixed startup wait comes before the first transaction, and each line then occupies a slot of line size over bus width (16 cycles). The slot grows by a fixed penalty when the source and destination sit at different offsets within a line. When the transfer ends, the block raises a one-cycle completion pulse and shows the total cycles it spent. It is meant as a cycle-accurate stand-in for a copy engine in performance models. The bus, arbitration and data movement are outside it.

Top module: `dmafrag_top`

## Requirements
- R1: `req_ready` is high exactly when no transfer is in progress. A request is taken in a cycle where `req_valid` and `req_ready` are both high. While a transfer runs, including its completion cycle, `req_ready` is low and `req_valid` has no effect.
- R2: Call the accepting cycle cycle 0. No transaction appears in cycles 1 to 200 (the startup wait). The first transaction of a non-empty transfer appears in cycle 201.
- R3: The number of transactions equals the number of distinct 128-byte source lines covered by bytes `req_src` to `req_src+req_len-1`.
- R4: `txn_addr` is the 128-byte-aligned address of the source line. Successive transactions of one transfer rise by 128.
- R5: Bit i of `txn_be` enables byte offset i of the line. The first transaction enables offsets from `req_src mod 128` upward. The last enables offsets up to `(req_src+req_len-1) mod 128`. Middle transactions enable all 128 bytes. A single-line transfer applies both limits.
- R6: `txn_last` is high on the final transaction of a transfer and low on all others.
- R7: When `req_dst_off` equals `req_src mod 128`, consecutive transactions are 16 cycles apart.
- R8: When `req_dst_off` differs from `req_src mod 128`, each line slot lasts 16+16 = 32 cycles.
- R9: For n lines and slot length L, `done` is high for exactly one cycle, at cycle 200+n·L+1. During that cycle `elapsed` equals 200+n·L, and it keeps that value until the next request is taken.
- R10: A zero-length request issues no transaction. It raises `done` at cycle 201 with `elapsed` equal to 200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_src | input | 32 | Source byte address |
| req_dst_off | input | 7 | Destination byte offset within a line |
| req_len | input | 16 | Byte count |
| txn_valid | output | 1 | One-cycle strobe marking a transaction |
| txn_addr | output | 32 | Line-aligned source address of the transaction |
| txn_be | output | 128 | Byte enables, bit i for line offset i |
| txn_last | output | 1 | Final transaction of the transfer |
| done | output | 1 | One-cycle completion pulse |
| elapsed | output | 32 | Total cycles of the latest transfer |

## Verification
Two functions coincide in a single-line transfer: the first-block lower trim and the last-block upper trim apply to the same transaction. The bench provokes this with short copies that start mid-line, including one that ends exactly on a line boundary. It compares the full mask against one built from the offsets. Completion and a new request also meet in one cycle: the bench holds a second request asserted from the moment the first is accepted. Its model expects `req_ready` to stay low through the `done` cycle and the second transfer to start only on the idle cycle after it.

// File: rtl/dmafrag_pkg.sv
// Shared types for the line-splitting copy engine.
package dmafrag_pkg;
    // Sequencer phases: idle, startup wait, per-line slots, completion pulse.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_BLOCK = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;
endpackage

// File: rtl/dmafrag_plan.sv
// Request planner: derives the line count, the first and last byte offsets and
// the alignment relation from a request. Purely combinational.
// Assumes LEN_W + 1 bits hold offset + length without overflow.
module dmafrag_plan #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int OFF_W  = 7,
    parameter int BLK_W  = LEN_W + 2 - OFF_W
) (
    input  logic [ADDR_W-1:0] src,
    input  logic [OFF_W-1:0]  dst_off,
    input  logic [LEN_W-1:0]  len,
    output logic [BLK_W-1:0]  nblk,
    output logic              misal,
    output logic [OFF_W-1:0]  first_off,
    output logic [OFF_W-1:0]  last_off,
    output logic [ADDR_W-OFF_W-1:0] first_line
);
    localparam int SUM_W = LEN_W + 1;

    logic [SUM_W-1:0] end_rel;

    // Offset of the final byte relative to the start of the first line.
    always_comb begin
        end_rel    = SUM_W'(len) + SUM_W'(src[OFF_W-1:0]) - SUM_W'(1);
        first_off  = src[OFF_W-1:0];
        last_off   = end_rel[OFF_W-1:0];
        first_line = src[ADDR_W-1:OFF_W];
        misal      = (src[OFF_W-1:0] != dst_off);
        nblk       = (len == '0) ? '0 : (BLK_W'(end_rel[SUM_W-1:OFF_W]) + BLK_W'(1));
    end
endmodule

// File: rtl/dmafrag_bemask.sv
// Byte-enable mask generator: bit i is set when lo <= i <= hi.
// Assumes lo <= hi whenever the mask is used.
module dmafrag_bemask #(
    parameter int LINE_BYTES = 128,
    parameter int OFF_W      = $clog2(LINE_BYTES)
) (
    input  logic [OFF_W-1:0]      lo,
    input  logic [OFF_W-1:0]      hi,
    output logic [LINE_BYTES-1:0] be
);
    // One comparator pair per byte lane.
    for (genvar gi = 0; gi < LINE_BYTES; gi++) begin : g_lane
        assign be[gi] = (OFF_W'(gi) >= lo) && (OFF_W'(gi) <= hi);
    end
endmodule

// File: rtl/dmafrag_ctrl.sv
// Transfer sequencer: counts the startup wait, then one slot per line, then a
// completion cycle; accumulates elapsed cycles. Assumes STARTUP >= 1.
module dmafrag_ctrl
    import dmafrag_pkg::*;
#(
    parameter int STARTUP    = 200,
    parameter int LINE_BEATS = 16,
    parameter int PENALTY    = 16,
    parameter int BLK_W      = 11,
    parameter int CNT_W      = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [BLK_W-1:0] nblk_in,
    input  logic             misal_in,
    output phase_e           phase,
    output logic             slot_start,
    output logic             blk_first,
    output logic             blk_last,
    output logic [CNT_W-1:0] elapsed
);
    localparam int SLOT_MAX = LINE_BEATS + PENALTY;
    localparam int TMR_MAX  = (STARTUP > SLOT_MAX) ? STARTUP : SLOT_MAX;
    localparam int TMR_W    = $clog2(TMR_MAX + 1);

    logic [TMR_W-1:0] timer;
    logic [TMR_W-1:0] slot_load;
    logic [BLK_W-1:0] remain;
    logic             misal_q;

    // Reload value for a line slot, stretched when offsets disagree.
    always_comb begin
        slot_load = misal_q ? TMR_W'(SLOT_MAX - 1) : TMR_W'(LINE_BEATS - 1);
        blk_last  = (remain == BLK_W'(1));
    end

    // Phase, timer, remaining-line and elapsed-cycle bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            timer      <= '0;
            remain     <= '0;
            misal_q    <= 1'b0;
            slot_start <= 1'b0;
            blk_first  <= 1'b0;
            elapsed    <= '0;
        end else begin
            slot_start <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        phase   <= PH_START;
                        timer   <= TMR_W'(STARTUP - 1);
                        remain  <= nblk_in;
                        misal_q <= misal_in;
                        elapsed <= '0;
                    end
                end
                PH_START: begin
                    elapsed <= elapsed + CNT_W'(1);
                    if (timer == '0) begin
                        if (remain == '0) begin
                            phase <= PH_DONE;
                        end else begin
                            phase      <= PH_BLOCK;
                            timer      <= slot_load;
                            slot_start <= 1'b1;
                            blk_first  <= 1'b1;
                        end
                    end else begin
                        timer <= timer - TMR_W'(1);
                    end
                end
                PH_BLOCK: begin
                    elapsed <= elapsed + CNT_W'(1);
                    if (timer == '0) begin
                        if (remain == BLK_W'(1)) begin
                            phase <= PH_DONE;
                        end else begin
                            timer      <= slot_load;
                            remain     <= remain - BLK_W'(1);
                            slot_start <= 1'b1;
                            blk_first  <= 1'b0;
                        end
                    end else begin
                        timer <= timer - TMR_W'(1);
                    end
                end
                PH_DONE: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_ELAPSED_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DONE) |-> (elapsed >= CNT_W'(STARTUP))); // R2
    AST_ELAPSED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !accept) |=> $stable(elapsed)); // R9
    AST_SLOT_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        slot_start |-> (phase == PH_BLOCK)); // R2
endmodule

// File: rtl/dmafrag_top.sv
// Line-splitting copy engine: takes one copy request at a time, emits one
// line transaction per source line touched, with cost-model timing, and
// reports the elapsed cycle total with a one-cycle done pulse.
// Assumes a single outstanding request; data movement happens elsewhere.
module dmafrag_top
    import dmafrag_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int LINE_BYTES = 128,
    parameter int BUS_BYTES  = 8,
    parameter int STARTUP    = 200,
    parameter int PENALTY    = 16,
    parameter int CNT_W      = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ADDR_W-1:0]     req_src,
    input  logic [$clog2(LINE_BYTES)-1:0] req_dst_off,
    input  logic [LEN_W-1:0]      req_len,
    output logic                  txn_valid,
    output logic [ADDR_W-1:0]     txn_addr,
    output logic [LINE_BYTES-1:0] txn_be,
    output logic                  txn_last,
    output logic                  done,
    output logic [CNT_W-1:0]      elapsed
);
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int LINE_W     = ADDR_W - OFF_W;
    localparam int BLK_W      = LEN_W + 2 - OFF_W;
    localparam int LINE_BEATS = LINE_BYTES / BUS_BYTES;

    phase_e            phase;
    logic              accept;
    logic              slot_start;
    logic              blk_first;
    logic              blk_last;
    logic [BLK_W-1:0]  plan_nblk;
    logic              plan_misal;
    logic [OFF_W-1:0]  plan_first_off;
    logic [OFF_W-1:0]  plan_last_off;
    logic [LINE_W-1:0] plan_first_line;
    logic [OFF_W-1:0]  first_off_q;
    logic [OFF_W-1:0]  last_off_q;
    logic [LINE_W-1:0] cur_line;
    logic [OFF_W-1:0]  mask_lo;
    logic [OFF_W-1:0]  mask_hi;
    logic [LINE_BYTES-1:0] mask;
    logic [ADDR_W-1:0] prev_txn_addr;

    dmafrag_plan #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .OFF_W(OFF_W), .BLK_W(BLK_W)
    ) u_plan (
        .src(req_src), .dst_off(req_dst_off), .len(req_len),
        .nblk(plan_nblk), .misal(plan_misal),
        .first_off(plan_first_off), .last_off(plan_last_off),
        .first_line(plan_first_line)
    );

    dmafrag_ctrl #(
        .STARTUP(STARTUP), .LINE_BEATS(LINE_BEATS), .PENALTY(PENALTY),
        .BLK_W(BLK_W), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .nblk_in(plan_nblk), .misal_in(plan_misal),
        .phase(phase), .slot_start(slot_start),
        .blk_first(blk_first), .blk_last(blk_last), .elapsed(elapsed)
    );

    dmafrag_bemask #(
        .LINE_BYTES(LINE_BYTES), .OFF_W(OFF_W)
    ) u_mask (
        .lo(mask_lo), .hi(mask_hi), .be(mask)
    );

    // Handshake and transaction outputs.
    always_comb begin
        req_ready = (phase == PH_IDLE);
        accept    = req_valid && req_ready;
        done      = (phase == PH_DONE);
        txn_valid = slot_start;
        txn_last  = slot_start && blk_last;
        txn_addr  = {cur_line, {OFF_W{1'b0}}};
        mask_lo   = blk_first ? first_off_q : '0;
        mask_hi   = blk_last ? last_off_q : '1;
        txn_be    = slot_start ? mask : '0;
    end

    // Latch request offsets and walk the source line address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_off_q <= '0;
            last_off_q  <= '0;
            cur_line    <= '0;
        end else if (accept) begin
            first_off_q <= plan_first_off;
            last_off_q  <= plan_last_off;
            cur_line    <= plan_first_line;
        end else if (slot_start) begin
            cur_line <= cur_line + LINE_W'(1);
        end
    end

    // Remember the previous transaction address for the stepping check.
    always_ff @(posedge clk) begin
        if (!rst_n)         prev_txn_addr <= '0;
        else if (txn_valid) prev_txn_addr <= txn_addr;
    end

    AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R1
    AST_NO_TXN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !txn_valid); // R3
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !blk_first) |-> (txn_addr == prev_txn_addr + ADDR_W'(LINE_BYTES))); // R4
    AST_BE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (|txn_be)); // R5
    AST_MIDDLE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !blk_first && !txn_last) |-> (&txn_be)); // R5
    AST_TXN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |=> !txn_valid); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
endmodule

// File: tb/dmafrag_top_tb.sv
// Bench with a behavioural per-cycle model; every output compared each cycle.
module dmafrag_top_tb;
    localparam int S    = 200;
    localparam int LINE = 128;
    localparam int BEAT = 16;
    localparam int PEN  = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_src = '0;
    logic [6:0]   req_dst_off = '0;
    logic [15:0]  req_len = '0;
    logic         txn_valid;
    logic [31:0]  txn_addr;
    logic [127:0] txn_be;
    logic         txn_last;
    logic         done;
    logic [31:0]  elapsed;

    int n_chk = 0;
    int n_fail = 0;

    // Model state.
    int m_busy = 0, m_t = 0, m_n = 0, m_slot = 0, m_src = 0, m_len = 0;
    int m_misal = 0, m_total = 0, last_total = 0, accept_cnt = 0, txn_seen = 0;

    always #5 clk = ~clk;

    dmafrag_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_src(req_src), .req_dst_off(req_dst_off), .req_len(req_len),
        .txn_valid(txn_valid), .txn_addr(txn_addr), .txn_be(txn_be),
        .txn_last(txn_last), .done(done), .elapsed(elapsed)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s t=%0d actual=%h expected=%h", tag, m_t, act, exp);
        end
    endtask

    function automatic logic [127:0] mk_be(input int lo, input int hi);
        logic [127:0] b;
        for (int i = 0; i < 128; i++) b[i] = (i >= lo) && (i <= hi);
        return b;
    endfunction

    // Model advance at each edge, from the inputs held stable since the last falling edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_t = 0; last_total = 0;
        end else if (m_busy == 0) begin
            if (req_valid) begin
                m_busy = 1; m_t = 1; m_src = int'(req_src); m_len = int'(req_len);
                m_misal = ((m_src % LINE) != int'(req_dst_off)) ? 1 : 0;
                m_slot = BEAT + (m_misal ? PEN : 0);
                m_n = (m_len == 0) ? 0 : ((m_src % LINE) + m_len - 1) / LINE + 1;
                m_total = S + m_n * m_slot;
                txn_seen = 0;
                accept_cnt++;
            end
        end else begin
            m_t++;
            if (m_t == m_total + 2) begin
                m_busy = 0; last_total = m_total;
            end
        end
    end

    // Compare all outputs once per cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            logic e_txn, e_done;
            int k, rel;
            string vtag;
            e_txn = 1'b0; e_done = 1'b0; k = 0;
            chk("R1 ready", {127'd0, req_ready}, {127'd0, (m_busy == 0)});
            if (m_busy != 0) begin
                rel = m_t - S - 1;
                if (rel >= 0 && rel < m_n * m_slot && (rel % m_slot) == 0) begin
                    e_txn = 1'b1; k = rel / m_slot;
                end
                e_done = (m_t == m_total + 1);
            end
            if (m_len == 0)          vtag = "R10 txn_valid";
            else if (m_t <= S)       vtag = "R2 txn_valid";
            else if (m_misal != 0)   vtag = "R8 txn_valid";
            else                     vtag = "R7 txn_valid";
            chk(vtag, {127'd0, txn_valid}, {127'd0, e_txn});
            if (txn_valid) txn_seen++;
            if (e_txn) begin
                chk("R4 txn_addr", {96'd0, txn_addr}, {96'd0, 32'((m_src / LINE + k) * LINE)});
                chk("R5 txn_be", txn_be,
                    mk_be((k == 0) ? (m_src % LINE) : 0,
                          (k == m_n - 1) ? ((m_src % LINE + m_len - 1) % LINE) : LINE - 1));
                chk("R6 txn_last", {127'd0, txn_last}, {127'd0, (k == m_n - 1)});
            end
            chk((m_len == 0) ? "R10 done" : "R9 done", {127'd0, done}, {127'd0, e_done});
            if (e_done) begin
                chk((m_len == 0) ? "R10 elapsed" : "R9 elapsed", {96'd0, elapsed}, {96'd0, 32'(m_total)});
                chk("R3 txn count", 128'(txn_seen), 128'(m_n));
            end else if (m_busy == 0) begin
                chk("R9 elapsed hold", {96'd0, elapsed}, {96'd0, 32'(last_total)});
            end
        end
    end

    task automatic issue(input int s, input int d, input int l);
        int c0;
        @(negedge clk);
        req_valid = 1'b1; req_src = 32'(s); req_dst_off = 7'(d % LINE); req_len = 16'(l);
        c0 = accept_cnt;
        while (accept_cnt == c0) @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_busy != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);                    // reset state is checked by the per-cycle compare (R1, R9)
        issue(32'h100, 32'h200, 128);  wait_idle();   // R7: aligned full line
        issue(32'h1010, 32'h2010, 20); wait_idle();   // R5: both trims in one transaction
        issue(32'h0F0, 32'h4F0, 300);  wait_idle();   // R3, R4: four lines
        issue(32'h20, 32'h10, 256);    wait_idle();   // R8: misaligned, three lines
        issue(32'h55, 32'h99, 0);      wait_idle();   // R10: zero length
        issue(32'h80, 32'h100, 1);     wait_idle();   // R7: offsets equal, addresses differ by 128
        issue(32'h40, 32'h40, 64);     wait_idle();   // R5: ends exactly at line end
        issue(32'h3000, 32'h3001, 64);                // R1: second request held through done
        issue(32'h37F, 32'h37F, 2);    wait_idle();   // R6: two lines, one byte each
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R9 watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule